// File: doc/BRIEF.md
# Hidden Configuration Register Window

This block sits on the slave side of a legacy disk-interface I/O port range of eight bytes. In its normal state every access inside the range is flagged as a task-file access and passed through to the drive. A short sequence of bus accesses opens a hidden bank of configuration registers: two consecutive 16-bit reads of base+1, followed by a byte write of 0x03 to base+2. While the bank is open, accesses in the range are served by the block and are not passed through. A byte write of 0x83 to base+2 closes the bank and restores normal decoding.

The bank holds two sets of timing registers, set A and set B, each with one read-cycle and one write-cycle value. It also holds a control register, a read-only strap register reporting the bus clock, and a miscellaneous register. Their contents drive per-drive timing outputs for the strobe logic downstream.

Top module: `hidden_cfg_window`

## Requirements
- R1: After reset the bank is closed, all four timing outputs equal the TIM_RST parameter (default 0x5B), the control register is 0x00 and the miscellaneous output is 0x00.
- R2: While the bank is closed, any access with an address in [BASE, BASE+7] asserts `taskfile_sel` in the same cycle, and `cfg_sel` stays low. `io_rdata` reads 0xFF and no register changes.
- R3: The bank opens on the cycle after this sequence: a 16-bit read at offset 1, then another 16-bit read at offset 1, then a byte write of 0x03 at offset 2, with no other in-range access in between. While open, in-range accesses assert `cfg_sel` and not `taskfile_sel`.
- R4: While the sequence is partly complete, any in-range access other than the next expected one returns the sequencer to its start. Examples are a byte read at offset 1, a third word read, or a write of any value other than 0x03. Out-of-range accesses do not disturb the sequencer.
- R5: While the bank is open, a byte write of 0x83 at offset 2 closes it from the next cycle. Other writes at offset 2 are ignored.
- R6: While the bank is open, reads return the following by offset: offsets 0 and 1 give the read-cycle and write-cycle timing of the selected set; offset 3 gives control; offset 5 gives strap; offset 6 gives miscellaneous. Offsets 2, 4 and 7 return 0xFF.
- R7: Strap bit 0 holds the value of `strap_pin` sampled while reset is asserted (1 = 25 MHz bus clock, 0 = 33 MHz), and bits 7:1 read 0. Later changes of the pin and writes at offset 5 have no effect. The bit is also driven on `clk25_strap`.
- R8: Writes and reads at offsets 0 and 1 address set B when both miscellaneous bit 0 and control bit 7 are 1. Otherwise they address set A.
- R9: Drive 0 timing outputs always show set A. Drive 1 timing outputs show set B when control bit 0 is 1, and set A when it is 0.
- R10: Accesses outside [BASE, BASE+7] assert neither select, read 0xFF and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strap_pin | input | 1 | Bus clock strap, sampled during reset |
| io_valid | input | 1 | Bus access present this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data (low byte) |
| io_rdata | output | 8 | Read data from the configuration bank, 0xFF otherwise |
| taskfile_sel | output | 1 | Access goes to the drive task file |
| cfg_sel | output | 1 | Access is served by the configuration bank |
| drv0_rd_tim | output | 8 | Drive 0 read-cycle timing |
| drv0_wr_tim | output | 8 | Drive 0 write-cycle timing |
| drv1_rd_tim | output | 8 | Drive 1 read-cycle timing |
| drv1_wr_tim | output | 8 | Drive 1 write-cycle timing |
| misc_out | output | 8 | Miscellaneous register contents |
| clk25_strap | output | 1 | Sampled strap bit |

## Verification
The assertions assume that a bus access is a single-cycle event whose address, direction, width and data hold steady around the clock edge. They also assume that reset is held for at least one clock edge, so the strap sample is taken. The stimulus meets both conditions: each access is driven on a falling edge, it lasts exactly one cycle, and reset covers several edges. The access sequences are built to cover complete, interrupted and relocking patterns, and they do not depend on which other task-file accesses a real driver would issue.

// File: rtl/hidden_cfg_window.sv
module hidden_cfg_window #(
  parameter logic [15:0] BASE    = 16'h01F0,
  parameter logic [7:0]  TIM_RST = 8'h5B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_pin,
  input  logic        io_valid,
  input  logic        io_write,
  input  logic        io_word,
  input  logic [15:0] io_addr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic        taskfile_sel,
  output logic        cfg_sel,
  output logic [7:0]  drv0_rd_tim,
  output logic [7:0]  drv0_wr_tim,
  output logic [7:0]  drv1_rd_tim,
  output logic [7:0]  drv1_wr_tim,
  output logic [7:0]  misc_out,
  output logic        clk25_strap
);
  localparam logic [2:0] OFF_RD    = 3'd0;
  localparam logic [2:0] OFF_WR    = 3'd1;
  localparam logic [2:0] OFF_KEY   = 3'd2;
  localparam logic [2:0] OFF_CTRL  = 3'd3;
  localparam logic [2:0] OFF_STRAP = 3'd5;
  localparam logic [2:0] OFF_MISC  = 3'd6;
  localparam logic [7:0] KEY_OPEN  = 8'h03;
  localparam logic [7:0] KEY_CLOSE = 8'h83;

  typedef enum logic [1:0] {ST_IDLE, ST_ONE, ST_TWO, ST_OPEN} seq_t;

  seq_t        st, st_nx;
  logic [15:0] rel;
  logic [2:0]  off;
  logic        hit, win_open, unlock_rd, key_open, key_close, bsel, cfg_wr;
  logic [7:0]  rd_tim [2];
  logic [7:0]  wr_tim [2];
  logic [7:0]  ctrl_q, misc_q;
  logic        strap_q;

  assign rel       = io_addr - BASE;
  assign off       = rel[2:0];
  assign hit       = io_valid && (rel[15:3] == 13'd0);
  assign win_open  = (st == ST_OPEN);
  assign unlock_rd = hit && !io_write && io_word && off == OFF_WR;
  assign key_open  = hit && io_write && !io_word && off == OFF_KEY && io_wdata == KEY_OPEN;
  assign key_close = hit && io_write && !io_word && off == OFF_KEY && io_wdata == KEY_CLOSE;
  assign bsel      = misc_q[0] & ctrl_q[7];
  assign cfg_sel      = hit && win_open;
  assign taskfile_sel = hit && !win_open;
  assign cfg_wr       = cfg_sel && io_write;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (unlock_rd) st_nx = ST_ONE;
      ST_ONE:  if (hit) st_nx = unlock_rd ? ST_TWO : ST_IDLE;
      ST_TWO:  if (hit) st_nx = key_open ? ST_OPEN : ST_IDLE;
      ST_OPEN: if (key_close) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;

  always_ff @(posedge clk)
    if (!rst_n) strap_q <= strap_pin;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_tim[0] <= TIM_RST;
      rd_tim[1] <= TIM_RST;
      wr_tim[0] <= TIM_RST;
      wr_tim[1] <= TIM_RST;
      ctrl_q    <= 8'h00;
      misc_q    <= 8'h00;
    end else if (cfg_wr) begin
      case (off)
        OFF_RD:   rd_tim[bsel] <= io_wdata;
        OFF_WR:   wr_tim[bsel] <= io_wdata;
        OFF_CTRL: ctrl_q       <= io_wdata;
        OFF_MISC: misc_q       <= io_wdata;
        default:  ;
      endcase
    end

  always_comb begin
    io_rdata = 8'hFF;
    if (cfg_sel && !io_write)
      case (off)
        OFF_RD:    io_rdata = rd_tim[bsel];
        OFF_WR:    io_rdata = wr_tim[bsel];
        OFF_CTRL:  io_rdata = ctrl_q;
        OFF_STRAP: io_rdata = {7'd0, strap_q};
        OFF_MISC:  io_rdata = misc_q;
        default:   io_rdata = 8'hFF;
      endcase
  end

  assign drv0_rd_tim = rd_tim[0];
  assign drv0_wr_tim = wr_tim[0];
  assign drv1_rd_tim = ctrl_q[0] ? rd_tim[1] : rd_tim[0];
  assign drv1_wr_tim = ctrl_q[0] ? wr_tim[1] : wr_tim[0];
  assign misc_out    = misc_q;
  assign clk25_strap = strap_q;

  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(taskfile_sel && cfg_sel)); // R2
  AST_OPEN_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(key_open && st == ST_TWO)); // R3
  AST_CLOSE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(win_open) |-> $past(key_close)); // R5
  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap_q)); // R7
  AST_GAP_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel && !io_write && (off == 3'd2 || off == 3'd4 || off == 3'd7)) |-> io_rdata == 8'hFF); // R6
  AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !hit) |-> (!taskfile_sel && !cfg_sel && io_rdata == 8'hFF)); // R10
endmodule

// File: tb/test_hidden_cfg_window.sv
module test_hidden_cfg_window;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] BASE = 16'h01F0;

  logic clk = 0, rst_n = 0, strap_pin = 1;
  logic io_valid = 0, io_write = 0, io_word = 0;
  logic [15:0] io_addr = 0;
  logic [7:0] io_wdata = 0;
  logic [7:0] io_rdata, drv0_rd_tim, drv0_wr_tim, drv1_rd_tim, drv1_wr_tim, misc_out;
  logic taskfile_sel, cfg_sel, clk25_strap;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference: progress 0..2 through the key, is_open flag
  int  prog;
  bit  is_open;
  byte unsigned m_rt[2], m_wt[2], m_ctrl, m_misc;
  bit  m_strap;

  always #(CLK_PERIOD/2) clk = ~clk;

  hidden_cfg_window #(.BASE(BASE)) i_hidden_cfg_window (
    .clk, .rst_n, .strap_pin, .io_valid, .io_write, .io_word, .io_addr, .io_wdata,
    .io_rdata, .taskfile_sel, .cfg_sel, .drv0_rd_tim, .drv0_wr_tim,
    .drv1_rd_tim, .drv1_wr_tim, .misc_out, .clk25_strap);

  task automatic chk(string tag, string what, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic int sel_set();
    return (m_misc[0] && m_ctrl[7]) ? 1 : 0;
  endfunction

  task automatic compare_all();
    int s = sel_set();
    int in = io_valid && (io_addr >= BASE) && (io_addr < BASE + 8);
    int o = io_addr - BASE;
    int exp_rd = 'hFF;
    if (in && is_open && !io_write)
      case (o)
        0: exp_rd = m_rt[s];
        1: exp_rd = m_wt[s];
        3: exp_rd = m_ctrl;
        5: exp_rd = m_strap;
        6: exp_rd = m_misc;
        default: exp_rd = 'hFF;
      endcase
    chk("R2", "taskfile_sel", taskfile_sel, in && !is_open);
    chk("R3", "cfg_sel", cfg_sel, in && is_open);
    chk("R6", "io_rdata", io_rdata, exp_rd);
    chk("R9", "drv0_rd", drv0_rd_tim, m_rt[0]);
    chk("R9", "drv0_wr", drv0_wr_tim, m_wt[0]);
    chk("R9", "drv1_rd", drv1_rd_tim, m_ctrl[0] ? m_rt[1] : m_rt[0]);
    chk("R9", "drv1_wr", drv1_wr_tim, m_ctrl[0] ? m_wt[1] : m_wt[0]);
    chk("R8", "misc_out", misc_out, m_misc);
    chk("R7", "clk25_strap", clk25_strap, m_strap);
  endtask

  task automatic model_step(bit v, bit w, bit wd, logic [15:0] a, logic [7:0] d);
    int in = v && (a >= BASE) && (a < BASE + 8);
    int o = a - BASE;
    bit urd = in && !w && wd && o == 1;
    bit kop = in && w && !wd && o == 2 && d == 8'h03;
    bit kcl = in && w && !wd && o == 2 && d == 8'h83;
    int s = sel_set();
    if (is_open) begin
      if (in && w)
        case (o)
          0: m_rt[s] = d;
          1: m_wt[s] = d;
          3: m_ctrl = d;
          6: m_misc = d;
          default: ;
        endcase
      if (kcl) is_open = 0;
    end else if (in) begin
      if (prog == 2) begin prog = 0; if (kop) is_open = 1; end
      else if (urd) prog = prog + 1;
      else prog = 0;
    end
  endtask

  task automatic acc(bit v, bit w, bit wd, logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_valid = v; io_write = w; io_word = wd; io_addr = a; io_wdata = d;
    #1 compare_all();
    @(posedge clk);
    model_step(v, w, wd, a, d);
  endtask

  task automatic idle(); acc(0, 0, 0, 16'h0, 8'h0); endtask
  task automatic rd(int o); acc(1, 0, 0, BASE + 16'(o), 8'h0); endtask
  task automatic wr(int o, logic [7:0] d); acc(1, 1, 0, BASE + 16'(o), d); endtask
  task automatic wrd1(); acc(1, 0, 1, BASE + 16'd1, 8'h0); endtask
  task automatic unlock(); wrd1(); wrd1(); wr(2, 8'h03); endtask

  initial begin
    prog = 0; is_open = 0; m_ctrl = 0; m_misc = 0; m_strap = 1;
    m_rt[0] = 8'h5B; m_rt[1] = 8'h5B; m_wt[0] = 8'h5B; m_wt[1] = 8'h5B;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; strap_pin = 0;
    // R1 reset state
    idle();
    chk("R1", "reset drv0_rd", drv0_rd_tim, 8'h5B);
    // R2 closed pass-through, writes have no effect
    rd(0); wr(0, 8'h11); wr(3, 8'h85); rd(6);
    // R10 outside range
    acc(1, 1, 0, BASE + 16'd8, 8'h22); acc(1, 0, 1, BASE - 16'd1, 8'h0);
    // R3 full unlock, R6 read map
    unlock();
    for (int o = 0; o < 8; o++) rd(o);
    // R7 strap ignores writes
    wr(5, 8'h00); rd(5);
    // R8 set B gated by control bit 7
    wr(0, 8'h45); wr(1, 8'h32); wr(6, 8'h01); wr(0, 8'h21); rd(0);
    wr(3, 8'hC0); wr(0, 8'h10); wr(1, 8'h20); rd(0); rd(1);
    wr(6, 8'h00); rd(0); rd(1);
    // R9 drive mapping
    wr(3, 8'h85); idle(); wr(3, 8'h04); idle(); wr(3, 8'h85); idle();
    // R5 wrong key at offset 2 ignored, then relock
    wr(2, 8'h03); rd(3); wr(2, 8'h83); rd(3); wr(0, 8'h77); idle();
    // R4 broken sequences
    wrd1(); rd(1); wrd1(); wr(2, 8'h03); rd(0);
    wrd1(); wrd1(); wrd1(); wr(2, 8'h03); rd(0);
    wrd1(); wrd1(); wr(2, 8'h04); wr(2, 8'h03); rd(0);
    wrd1(); rd(0); wrd1(); wrd1(); wr(2, 8'h03); rd(3);
    // R4 out-of-range access does not break the key
    wr(2, 8'h83); wrd1(); acc(1, 0, 1, 16'h0170, 8'h0); wrd1(); wr(2, 8'h03); rd(6);
    wr(2, 8'h83); idle();
    chk("R5", "closed after relock", cfg_sel, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule